// File: doc/BRIEF.md
# Delayed-Select SPI Word Master

This block shifts one 16-bit word at a time out of and into an SPI bus, as a master, and adds timing around the active-low chip select. A single control word holds a run bit at the top and two delay counts beneath it. Software loads the command inputs (the outgoing word and two per-command flags) and writes the control word with the run bit set. The engine then pulls chip select low, waits a lead interval, clocks the 16 bits, waits a tail interval and releases chip select.

The lead interval runs from the fall of chip select to the first serial clock transition. When its command flag is set it comes from the 7-bit field of the control word; otherwise it is half a serial clock period. The tail interval runs from the last serial clock transition to the rise of chip select. When its command flag is set it comes from the 8-bit field; otherwise it is one system clock. The run bit clears itself when chip select rises. Software can abort by writing the run bit to zero, unless the abort-lock input is high. A halt input ends the transfer cleanly once the current word has finished.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, rx_valid is 0 and ctl_rdata is all zeros.
- R2: A control write with bit 15 set while the engine is idle starts a transfer. busy rises on the next clock, cs_n goes low one clock later, and ctl_rdata bit 15 reads 1 while the transfer runs.
- R3: A transfer makes exactly 32 sck transitions spaced sck_half system clocks apart (a value of 0 means 256). The word is sent MSB first, and the 16 received bits appear on rx_data with a one-cycle rx_valid pulse in the cycle cs_n rises.
- R4: sck rests at the cpol level. With cpha=0, mosi changes on trailing edges and miso is sampled on leading edges. With cpha=1, mosi changes on leading edges and miso is sampled on trailing edges. cpol and cpha are latched when the transfer starts.
- R5: The first sck transition comes N system clocks after cs_n falls. With cmd_lead_dly=1, N is control bits 14:8, where 0 means 128. With cmd_lead_dly=0, N equals the sck half period.
- R6: cs_n rises M system clocks after the last sck transition, and busy falls in the same cycle. With cmd_trail_dly=1, M is control bits 7:0, where 0 means 256. With cmd_trail_dly=0, M is 1.
- R7: Control bit 15 clears by itself in the cycle cs_n rises at the end of a transfer.
- R8: A control write with bit 15 clear during a transfer, while abort_lock is 0, aborts it. On the next clock cs_n is 1, busy is 0 and bit 15 reads 0, and no rx_valid pulse follows.
- R9: The same write while abort_lock is 1 is ignored: the transfer continues and completes normally.
- R10: If halt_req is seen during a transfer, the current word still completes with all 32 transitions and rx_valid. The tail interval is forced to 1 clock, and bit 15 clears.
- R11: Every control write updates bits 14:8 and 7:0, and ctl_rdata reads them back at those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control write data: run bit 15, lead count 14:8, tail count 7:0 |
| ctl_rdata | output | 16 | Control word readback |
| abort_lock | input | 1 | When high, software clears of the run bit are ignored |
| halt_req | input | 1 | Request a clean stop at the end of the current word |
| cmd_lead_dly | input | 1 | Command flag: use the programmed lead count |
| cmd_trail_dly | input | 1 | Command flag: use the programmed tail count |
| cmd_tx | input | 16 | Word to transmit |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase select |
| sck_half | input | 8 | Serial clock half period in system clocks (0 means 256) |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High from the start write until cs_n rises |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| rx_data | output | 16 | Last received word |

## Verification
The assertions check the control-word handshake on every cycle. A start write is followed by busy. An unlocked abort releases chip select and clears the run bit on the next clock. A locked abort leaves the transfer running. busy low always implies chip select high, busy falls only with the run bit clear, and rx_valid is a single pulse tied to a rising chip select. The lead and tail interval lengths, the transition count and spacing, the bit order in both phase modes, the zero-means-maximum counts and the halt behaviour depend on counting cycles over a whole word. Only the bench scenarios show those, using a loopback with optional inversion on miso.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_DONE
  } xfer_state_t;
endpackage

// File: rtl/spi_dly_timer.sv
// Down-counter shared by the lead, half-period and tail intervals.
module spi_dly_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         at_one
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign at_one = (cnt_q == W'(1));
endmodule

// File: rtl/spi_ctl_reg.sv
// Control word: run bit on top, lead count, tail count.
module spi_ctl_reg #(
  parameter int LEAD_W  = 7,
  parameter int TRAIL_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [LEAD_W+TRAIL_W:0]   wdata,
  input  logic                      abort_lock,
  input  logic                      fsm_idle,
  input  logic                      auto_clr,
  output logic                      start,
  output logic                      abort,
  output logic [LEAD_W-1:0]         lead_f,
  output logic [TRAIL_W-1:0]        trail_f,
  output logic [LEAD_W+TRAIL_W:0]   rdata
);
  localparam int RUN_BIT = LEAD_W + TRAIL_W;

  logic run_q;

  assign start = wr &&  wdata[RUN_BIT] && !run_q && fsm_idle;
  assign abort = wr && !wdata[RUN_BIT] &&  run_q && !abort_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      lead_f  <= '0;
      trail_f <= '0;
    end else begin
      if (auto_clr)   run_q <= 1'b0;
      else if (start) run_q <= 1'b1;
      else if (abort) run_q <= 1'b0;
      if (wr) begin
        lead_f  <= wdata[RUN_BIT-1:TRAIL_W];
        trail_f <= wdata[TRAIL_W-1:0];
      end
    end
  end

  assign rdata = {run_q, lead_f, trail_f};
endmodule

// File: rtl/spi_word_shifter.sv
// Transmit and receive shift registers; the phase mode picks which edges change and which sample.
module spi_word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_cpha,
  input  logic              edge_go,
  input  logic              edge_lead,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sh;
  logic              cpha_q;
  logic              change_edge;

  assign change_edge = cpha_q ? edge_lead : !edge_lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
      cpha_q  <= 1'b0;
    end else if (load) begin
      cpha_q <= load_cpha;
      mosi   <= load_word[WORD_W-1];
      tx_sh  <= load_cpha ? load_word : {load_word[WORD_W-2:0], 1'b0};
    end else if (edge_go) begin
      if (change_edge) begin
        mosi  <= tx_sh[WORD_W-1];
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end else begin
        rx_word <= {rx_word[WORD_W-2:0], miso};
      end
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LEAD_W  = 7,
  parameter int TRAIL_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctl_wr,
  input  logic [LEAD_W+TRAIL_W:0] ctl_wdata,
  output logic [LEAD_W+TRAIL_W:0] ctl_rdata,
  input  logic                    abort_lock,
  input  logic                    halt_req,
  input  logic                    cmd_lead_dly,
  input  logic                    cmd_trail_dly,
  input  logic [WORD_W-1:0]       cmd_tx,
  input  logic                    cpol,
  input  logic                    cpha,
  input  logic [DIV_W-1:0]        sck_half,
  input  logic                    miso,
  output logic                    sck,
  output logic                    mosi,
  output logic                    cs_n,
  output logic                    busy,
  output logic                    rx_valid,
  output logic [WORD_W-1:0]       rx_data
);
  localparam int MAXW      = (LEAD_W > TRAIL_W) ? ((LEAD_W > DIV_W) ? LEAD_W : DIV_W)
                                                : ((TRAIL_W > DIV_W) ? TRAIL_W : DIV_W);
  localparam int TMR_W     = MAXW + 1;
  localparam int LEAD_MAX  = 1 << LEAD_W;
  localparam int TRAIL_MAX = 1 << TRAIL_W;
  localparam int DIV_MAX   = 1 << DIV_W;
  localparam int N_EDGES   = 2 * WORD_W;
  localparam int EDGE_W    = $clog2(N_EDGES);

  xfer_state_t         state_q;
  logic                cpol_q, lead_en_q, trail_en_q, halt_pend_q;
  logic [EDGE_W-1:0]   edge_q;
  logic                start, abort, auto_clr, tmr_one;
  logic                tmr_load, edge_go, last_edge;
  logic [TMR_W-1:0]    tmr_val, lead_n, trail_n, half_n;
  logic [LEAD_W-1:0]   lead_f;
  logic [TRAIL_W-1:0]  trail_f;
  logic [WORD_W-1:0]   rx_word;

  spi_ctl_reg #(.LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W)) u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .abort_lock(abort_lock),
    .fsm_idle(state_q == ST_IDLE), .auto_clr(auto_clr), .start(start), .abort(abort),
    .lead_f(lead_f), .trail_f(trail_f), .rdata(ctl_rdata)
  );

  // Interval lengths; a zero field or divider means the largest count.
  assign half_n  = (sck_half == '0) ? TMR_W'(DIV_MAX) : TMR_W'(sck_half);
  assign lead_n  = !lead_en_q ? half_n
                 : (lead_f == '0) ? TMR_W'(LEAD_MAX) : TMR_W'(lead_f);
  assign trail_n = (halt_req || halt_pend_q || !trail_en_q) ? TMR_W'(1)
                 : (trail_f == '0) ? TMR_W'(TRAIL_MAX) : TMR_W'(trail_f);

  assign edge_go   = tmr_one && (state_q == ST_LEAD || state_q == ST_SHIFT);
  assign last_edge = (edge_q == EDGE_W'(N_EDGES - 1));
  assign auto_clr  = (state_q == ST_TRAIL) && tmr_one && !abort;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = half_n;
    if (state_q == ST_CS) begin
      tmr_load = 1'b1;
      tmr_val  = lead_n;
    end else if (edge_go) begin
      tmr_load = 1'b1;
      tmr_val  = (state_q == ST_SHIFT && last_edge) ? trail_n : half_n;
    end
  end

  spi_dly_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .at_one(tmr_one)
  );

  spi_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_word(cmd_tx), .load_cpha(cpha),
    .edge_go(edge_go && !abort), .edge_lead(!edge_q[0]), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sck         <= 1'b0;
      cs_n        <= 1'b1;
      busy        <= 1'b0;
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      cpol_q      <= 1'b0;
      lead_en_q   <= 1'b0;
      trail_en_q  <= 1'b0;
      halt_pend_q <= 1'b0;
      edge_q      <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (state_q != ST_IDLE && halt_req) halt_pend_q <= 1'b1;
      if (abort) begin
        state_q     <= ST_IDLE;
        cs_n        <= 1'b1;
        busy        <= 1'b0;
        sck         <= cpol_q;
        halt_pend_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            sck         <= cpol;
            halt_pend_q <= 1'b0;
            if (start) begin
              busy       <= 1'b1;
              cpol_q     <= cpol;
              lead_en_q  <= cmd_lead_dly;
              trail_en_q <= cmd_trail_dly;
              state_q    <= ST_CS;
            end
          end
          ST_CS: begin
            cs_n    <= 1'b0;
            edge_q  <= '0;
            state_q <= ST_LEAD;
          end
          ST_LEAD: if (tmr_one) begin
            sck     <= ~sck;
            edge_q  <= edge_q + 1'b1;
            state_q <= ST_SHIFT;
          end
          ST_SHIFT: if (tmr_one) begin
            sck    <= ~sck;
            edge_q <= edge_q + 1'b1;
            if (last_edge) state_q <= ST_TRAIL;
          end
          ST_TRAIL: if (tmr_one) begin
            cs_n     <= 1'b1;
            busy     <= 1'b0;
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
            state_q  <= ST_DONE;
          end
          ST_DONE: state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
  parameter int CTL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             abort_lock,
  input logic             busy,
  input logic             cs_n,
  input logic             rx_valid
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ctl_rdata[CTL_W-1] && ctl_wr && ctl_wdata[CTL_W-1]) |=> busy);

  // R6
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R7
  run_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !ctl_rdata[CTL_W-1]);

  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_rdata[CTL_W-1] && !abort_lock && ctl_wr && !ctl_wdata[CTL_W-1])
      |=> (!busy && cs_n && !ctl_rdata[CTL_W-1]));

  // R9
  locked_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && abort_lock && ctl_wr && !ctl_wdata[CTL_W-1]) |=> (busy || $rose(cs_n)));

  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($rose(cs_n) && !busy));

  // R3
  rx_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind spi_xfer_engine spi_xfer_chk #(.CTL_W(1 + LEAD_W + TRAIL_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .abort_lock(abort_lock), .busy(busy), .cs_n(cs_n), .rx_valid(rx_valid)
);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        abort_lock = 1'b0, halt_req = 1'b0;
  logic        cmd_lead_dly = 1'b0, cmd_trail_dly = 1'b0;
  logic [15:0] cmd_tx = '0;
  logic        cpol = 1'b0, cpha = 1'b0;
  logic [7:0]  sck_half = 8'd2;
  logic        miso, sck, mosi, cs_n, busy, rx_valid;
  logic [15:0] rx_data;
  logic        inv = 1'b0;

  int checks = 0, fails = 0, cyc = 0, rxv_seen = 0;

  typedef struct {
    int          lead;
    int          trail;
    int          half;
    logic [15:0] rx;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign miso = mosi ^ inv;

  spi_xfer_engine u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .abort_lock(abort_lock), .halt_req(halt_req), .cmd_lead_dly(cmd_lead_dly),
    .cmd_trail_dly(cmd_trail_dly), .cmd_tx(cmd_tx), .cpol(cpol), .cpha(cpha),
    .sck_half(sck_half), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: measures intervals and transitions, compares against the queue head.
  logic prev_cs = 1'b1, prev_sck = 1'b0;
  int t_fall, t_first, t_last, n_edge, gap_bad, cur_half;
  always @(negedge clk) begin
    if (rx_valid) rxv_seen++;
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        t_fall = cyc; n_edge = 0; gap_bad = 0;
        cur_half = (exp_q.size() > 0) ? exp_q[0].half : 0;
      end
      if (!cs_n && sck != prev_sck) begin
        if (n_edge == 0) t_first = cyc;
        else if (cyc - t_last != cur_half) gap_bad++;
        t_last = cyc;
        n_edge++;
      end
      if (!prev_cs && cs_n && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(t_first - t_fall == e.lead, "R5", {e.tag, " lead"}, t_first - t_fall, e.lead);
        chk(cyc - t_last == e.trail, "R6", {e.tag, " trail"}, cyc - t_last, e.trail);
        chk(n_edge == 32 && gap_bad == 0, "R3", {e.tag, " edges"}, n_edge, 32);
        chk(rx_valid && rx_data == e.rx, "R4", {e.tag, " rx word"}, rx_data, e.rx);
      end
    end
    prev_cs  = cs_n;
    prev_sck = sck;
  end

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic start_xfer(input logic pol, input logic pha, input logic le, input logic te,
                            input logic [6:0] lf, input logic [7:0] tf, input logic [7:0] dv,
                            input logic [15:0] tx, input logic iv, input logic hlt,
                            input string tag);
    exp_t e;
    int h;
    @(negedge clk);
    cpol = pol; cpha = pha; cmd_lead_dly = le; cmd_trail_dly = te;
    sck_half = dv; cmd_tx = tx; inv = iv;
    h = (dv == 0) ? 256 : dv;
    e.half  = h;
    e.lead  = le ? ((lf == 0) ? 128 : lf) : h;
    e.trail = hlt ? 1 : (te ? ((tf == 0) ? 256 : tf) : 1);
    e.rx    = tx ^ {16{iv}};
    e.tag   = tag;
    exp_q.push_back(e);
    wr_ctl({1'b1, lf, tf});
    chk(busy && ctl_rdata[15], "R2", {tag, " started"}, {busy, ctl_rdata[15]}, 2'b11);
    chk(ctl_rdata[14:0] == {lf, tf}, "R11", {tag, " fields"}, ctl_rdata[14:0], {lf, tf});
  endtask

  task automatic finish_xfer(input string tag);
    while (busy) @(negedge clk);
    chk(!ctl_rdata[15] && cs_n, "R7", {tag, " run bit cleared"}, ctl_rdata[15], 0);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3", {tag, " completion seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int rxv0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cs_n && !sck && !busy && !rx_valid && ctl_rdata == 16'h0, "R1", "reset state",
        {cs_n, sck, busy, rx_valid, ctl_rdata}, {4'b1000, 16'h0});

    start_xfer(0, 1, 0, 0, 7'd9, 8'd9, 8'd2, 16'hA5C3, 0, 0, "m01 default delays");
    finish_xfer("m01");
    start_xfer(1, 0, 1, 1, 7'd5, 8'd7, 8'd3, 16'h3C96, 1, 0, "m10 programmed delays");
    finish_xfer("m10");
    start_xfer(0, 0, 1, 1, 7'd0, 8'd0, 8'd1, 16'h8001, 0, 0, "m00 zero fields");
    finish_xfer("m00");
    start_xfer(1, 1, 0, 1, 7'd3, 8'd1, 8'd0, 16'h5AF0, 1, 0, "m11 zero divider");
    finish_xfer("m11");
    // R4: idle level follows cpol between transfers
    @(negedge clk); cpol = 1'b1; @(negedge clk); @(negedge clk);
    chk(sck == 1'b1, "R4", "idle sck at cpol=1", sck, 1);
    cpol = 1'b0; @(negedge clk); @(negedge clk);

    // R8: unlocked abort mid-shift
    exp_q.delete();
    start_xfer(0, 1, 1, 1, 7'd4, 8'd20, 8'd4, 16'hFFFF, 0, 0, "abort");
    exp_q.delete();
    repeat (30) @(negedge clk);
    rxv0 = rxv_seen;
    wr_ctl({1'b0, 7'd4, 8'd20});
    chk(cs_n && !busy && !ctl_rdata[15], "R8", "abort releases",
        {cs_n, busy, ctl_rdata[15]}, 3'b100);
    repeat (300) @(negedge clk);
    chk(rxv_seen == rxv0 && cs_n, "R8", "no rx pulse after abort", rxv_seen - rxv0, 0);

    // R9: locked abort ignored
    abort_lock = 1'b1;
    start_xfer(1, 0, 1, 0, 7'd10, 8'd3, 8'd2, 16'h1234, 0, 0, "locked");
    repeat (20) @(negedge clk);
    wr_ctl({1'b0, 7'd10, 8'd3});
    chk(!cs_n && busy && ctl_rdata[15], "R9", "locked abort ignored",
        {cs_n, busy, ctl_rdata[15]}, 3'b011);
    finish_xfer("locked");
    abort_lock = 1'b0;

    // R10: halt during the lead interval
    start_xfer(0, 1, 1, 1, 7'd40, 8'd50, 8'd2, 16'hC0DE, 0, 1, "halt");
    repeat (3) @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    finish_xfer("R10 halt");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule